// File: doc/BRIEF.md
# Tape Controller Host Register Block

This block is the host-bus slave face of a tape subsystem controller. It has two word addresses. The base address accepts writes into an 18-bit data buffer. A read there returns the low 16 bits of an 18-bit bus address pointer. The status register sits at the second address. Host write data is rearranged into the buffer according to the write type. A full-word write carries the two top address bits in its two lowest data bits. Word and high-byte writes also copy the buffer into the pointer, with the two lowest pointer bits forced to zero. The byte writes act as loopback diagnostic modes.

The status register holds error flags, a subsystem-ready flag and transport-owned fields. The host cannot write it directly. Any write to the status address re-initializes the subsystem. A buffer write that arrives while the subsystem is busy still completes, but it is flagged as refused. The transport side updates its own status fields through a dedicated port and raises error flags through set pulses. A DMA engine steps the pointer up or down by word or by byte.

Top module: `tape_host_regs`

## Requirements
- R1: A full-word write (byte enables 2'b11) to the base address (sel 0) loads buffer bits 15:2 from data bits 15:2 and buffer bits 17:16 from data bits 1:0, and clears buffer bits 1:0.
- R2: Word and high-byte writes load the pointer from the new buffer value with pointer bits 1:0 zero. A base read returns pointer bits 15:0, and status bits 9:8 show pointer bits 17:16.
- R3: A high-byte write (byte enables 2'b10) loads buffer bits 15:8 and 7:0 both from data bits 15:8, and buffer bits 17:16 from data bits 9:8.
- R4: A low-byte write (byte enables 2'b01) loads buffer bits 15:0 from data bits 15:0. It keeps buffer bits 17:16 and leaves the pointer unchanged.
- R5: A DMA step moves the pointer by 2 (word) or 1 (byte), up or down, modulo 2^18. A host pointer load in the same cycle wins over the step.
- R6: A buffer write while ready (status bit 7) is clear sets bits 12 and 15 and leaves bit 7 clear. The buffer is still loaded, and no command-pointer strobe is emitted.
- R7: Every buffer write clears status bits 14, 13, 11 and 7. An accepted write also clears bit 12.
- R8: Reset and any write to the status address (sel 1) set the stored status to 16'h0400, with only the need-buffer flag (bit 10) set. A status-address write pulses the init strobe once and leaves the buffer and the pointer untouched.
- R9: A transport update writes status bits 15, 10, 7 and 6:1 from its data, and status bit 0 always reads 0. Error set pulses set bit 14 (host parity), bit 13 (link parity) and bit 11 (nonexistent memory).
- R10: Every write with nonzero byte enables, and every status-address write, gets a one-cycle acknowledge in the next cycle. Only accepted full-word writes also give a one-cycle command-pointer strobe in that same cycle. A base write with byte enables 2'b00 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write, one cycle |
| host_sel_i | input | 1 | Register select: 0 base, 1 status |
| host_be_i | input | 2 | Byte enables: 11 word, 10 high byte, 01 low byte |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Read data for the selected register |
| host_ack_o | output | 1 | Write acknowledge pulse |
| cmd_load_o | output | 1 | Accepted command-pointer load strobe |
| sub_init_o | output | 1 | Subsystem initialize strobe |
| buf_o | output | 18 | Data buffer contents |
| ptr_o | output | 18 | Bus address pointer |
| dma_step_i | input | 1 | Step the pointer |
| dma_down_i | input | 1 | Step direction: 1 down |
| dma_byte_i | input | 1 | Step size: 1 byte, 0 word |
| xp_sts_we_i | input | 1 | Transport status update |
| xp_sts_i | input | 16 | Transport status data |
| err_hpe_i | input | 1 | Set host parity error flag |
| err_spe_i | input | 1 | Set link parity error flag |
| err_nxm_i | input | 1 | Set nonexistent memory flag |

## Verification
The bench builds the block with the default 18-bit pointer and 16-bit word. With these widths a word write of all ones puts the pointer at its top word address. Two upward word steps from there cover the wrap to zero, and one downward byte step covers the reverse wrap. The same widths let the bench compute the exact placement of the top address bits, both in the base read and in status bits 9:8, for every write type. This includes a refused write, a write that coincides with a DMA step, and an init that must leave the pointer alone.

// File: rtl/tape_regs_pkg.sv
package tape_regs_pkg;
  typedef enum logic [1:0] {WK_NONE, WK_WORD, WK_HIGH, WK_LOW} wr_kind_e;

  localparam int unsigned ST_SC  = 15;
  localparam int unsigned ST_HPE = 14;
  localparam int unsigned ST_SPE = 13;
  localparam int unsigned ST_RMR = 12;
  localparam int unsigned ST_NXM = 11;
  localparam int unsigned ST_NBA = 10;
  localparam int unsigned ST_SSR = 7;

  localparam logic [15:0] ST_INIT    = 16'h0400;
  localparam logic [15:0] ST_XP_MASK = 16'h84FE; // 15, 10, 7, 6:1
  localparam logic [15:0] ST_PTR_HI  = 16'h0300;
  localparam logic [15:0] ST_UNUSED  = 16'h0001;
endpackage

// File: rtl/thr_data_buf.sv
module thr_data_buf
  import tape_regs_pkg::*;
#(
  parameter int unsigned PTR_W  = 18,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  wr_kind_e          kind_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [PTR_W-1:0]  buf_d_o,
  output logic [PTR_W-1:0]  buf_q_o
);
  localparam int unsigned BYTE_W = WORD_W / 2;
  localparam int unsigned EXT_W  = PTR_W - WORD_W;

  logic [PTR_W-1:0] buf_q;

  always_comb begin
    buf_d_o = buf_q;
    unique case (kind_i)
      WK_WORD: begin
        buf_d_o[WORD_W-1:EXT_W]     = wdata_i[WORD_W-1:EXT_W];
        buf_d_o[EXT_W-1:0]          = '0;
        buf_d_o[PTR_W-1:WORD_W]     = wdata_i[EXT_W-1:0];
      end
      WK_HIGH: begin
        buf_d_o[WORD_W-1:BYTE_W]    = wdata_i[WORD_W-1:BYTE_W];
        buf_d_o[BYTE_W-1:0]         = wdata_i[WORD_W-1:BYTE_W];
        buf_d_o[PTR_W-1:WORD_W]     = wdata_i[BYTE_W+EXT_W-1:BYTE_W];
      end
      WK_LOW:  buf_d_o[WORD_W-1:0] = wdata_i;
      default: ;
    endcase
  end

  // no reset: contents survive init by design
  always_ff @(posedge clk_i)
    if (kind_i != WK_NONE) buf_q <= buf_d_o;

  assign buf_q_o = buf_q;
endmodule

// File: rtl/thr_addr_ptr.sv
module thr_addr_ptr #(
  parameter int unsigned PTR_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] ld_val_i,
  input  logic             step_i,
  input  logic             down_i,
  input  logic             byte_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] ALIGN_MASK = {{(PTR_W-2){1'b1}}, 2'b00};

  logic [PTR_W-1:0] ptr_q, delta;

  assign delta = byte_i ? PTR_W'(1) : PTR_W'(2);

  always_ff @(posedge clk_i) begin
    if (load_i)      ptr_q <= ld_val_i & ALIGN_MASK;
    else if (step_i) ptr_q <= down_i ? ptr_q - delta : ptr_q + delta;
  end

  assign ptr_o = ptr_q;

  AST_LOAD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ptr_q[1:0] == 2'b00)); // R2
  AST_WORD_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !down_i && !byte_i) |=> (ptr_q == $past(ptr_q) + PTR_W'(2))); // R5
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && step_i) |=> (ptr_q == ($past(ld_val_i) & ALIGN_MASK))); // R5
endmodule

// File: rtl/thr_status.sv
module thr_status
  import tape_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        buf_wr_i,
  input  logic        xp_we_i,
  input  logic [15:0] xp_sts_i,
  input  logic        err_hpe_i,
  input  logic        err_spe_i,
  input  logic        err_nxm_i,
  input  logic [1:0]  ptr_hi_i,
  output logic        ready_o,
  output logic [15:0] status_o
);
  logic [15:0] st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (xp_we_i)   st_n = (st_q & ~ST_XP_MASK) | (xp_sts_i & ST_XP_MASK);
    if (err_hpe_i) st_n[ST_HPE] = 1'b1;
    if (err_spe_i) st_n[ST_SPE] = 1'b1;
    if (err_nxm_i) st_n[ST_NXM] = 1'b1;
    if (buf_wr_i) begin
      st_n[ST_HPE] = 1'b0;
      st_n[ST_SPE] = 1'b0;
      st_n[ST_RMR] = 1'b0;
      st_n[ST_NXM] = 1'b0;
      st_n[ST_SSR] = 1'b0;
      if (!st_q[ST_SSR]) begin
        st_n[ST_RMR] = 1'b1;
        st_n[ST_SC]  = 1'b1;
      end
    end
    if (init_i) st_n = ST_INIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_INIT;
    else         st_q <= st_n;

  assign ready_o  = st_q[ST_SSR];
  assign status_o = (st_q & ~(ST_PTR_HI | ST_UNUSED)) | {6'b0, ptr_hi_i, 8'b0};

  AST_REFUSE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_wr_i && !ready_o && !init_i) |=> (status_o[ST_RMR] && status_o[ST_SC] && !ready_o)); // R6
  AST_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_wr_i && !init_i) |=> !(status_o[ST_HPE] || status_o[ST_SPE] || status_o[ST_NXM] || ready_o)); // R7
  AST_INIT_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (status_o[ST_NBA] && !ready_o && !status_o[ST_SC])); // R8
  AST_NXM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_nxm_i && !buf_wr_i && !init_i) |=> status_o[ST_NXM]); // R9
endmodule

// File: rtl/tape_host_regs.sv
module tape_host_regs
  import tape_regs_pkg::*;
#(
  parameter int unsigned PTR_W  = 18,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_sel_i,
  input  logic [1:0]        host_be_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic              host_ack_o,
  output logic              cmd_load_o,
  output logic              sub_init_o,
  output logic [PTR_W-1:0]  buf_o,
  output logic [PTR_W-1:0]  ptr_o,
  input  logic              dma_step_i,
  input  logic              dma_down_i,
  input  logic              dma_byte_i,
  input  logic              xp_sts_we_i,
  input  logic [15:0]       xp_sts_i,
  input  logic              err_hpe_i,
  input  logic              err_spe_i,
  input  logic              err_nxm_i
);
  wr_kind_e          kind;
  logic              base_wr, init, buf_wr, ptr_load, ready;
  logic [PTR_W-1:0]  buf_d, ptr;
  logic [15:0]       status;
  logic              ack_q, cmd_q, init_q;

  assign base_wr = host_wr_i && !host_sel_i;
  assign init    = host_wr_i && host_sel_i;

  always_comb begin
    kind = WK_NONE;
    if (base_wr) begin
      unique case (host_be_i)
        2'b11:   kind = WK_WORD;
        2'b10:   kind = WK_HIGH;
        2'b01:   kind = WK_LOW;
        default: kind = WK_NONE;
      endcase
    end
  end

  assign buf_wr   = (kind != WK_NONE);
  assign ptr_load = (kind == WK_WORD) || (kind == WK_HIGH);

  thr_data_buf #(.PTR_W(PTR_W), .WORD_W(WORD_W)) u_buf (
    .clk_i   (clk_i),
    .kind_i  (kind),
    .wdata_i (host_wdata_i),
    .buf_d_o (buf_d),
    .buf_q_o (buf_o)
  );

  thr_addr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ptr_load),
    .ld_val_i (buf_d),
    .step_i   (dma_step_i),
    .down_i   (dma_down_i),
    .byte_i   (dma_byte_i),
    .ptr_o    (ptr)
  );

  thr_status u_sts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init),
    .buf_wr_i  (buf_wr),
    .xp_we_i   (xp_sts_we_i),
    .xp_sts_i  (xp_sts_i),
    .err_hpe_i (err_hpe_i),
    .err_spe_i (err_spe_i),
    .err_nxm_i (err_nxm_i),
    .ptr_hi_i  (ptr[PTR_W-1:PTR_W-2]),
    .ready_o   (ready),
    .status_o  (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      cmd_q  <= 1'b0;
      init_q <= 1'b0;
    end else begin
      ack_q  <= buf_wr || init;
      cmd_q  <= (kind == WK_WORD) && ready && !init;
      init_q <= init;
    end

  assign host_ack_o   = ack_q;
  assign cmd_load_o   = cmd_q;
  assign sub_init_o   = init_q;
  assign ptr_o        = ptr;
  assign host_rdata_o = host_sel_i ? status : ptr[WORD_W-1:0];

  AST_CMD_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_load_o |-> host_ack_o); // R10
  AST_NO_CMD_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_wr && !ready) |=> !cmd_load_o); // R6
endmodule

// File: tb/tape_host_regs_test.sv
module tape_host_regs_test;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 0, sel = 0;
  logic [1:0]  be = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        ack, cmd_load, sub_init;
  logic [17:0] bufv, ptrv;
  logic        step = 0, down = 0, bstep = 0;
  logic        xp_we = 0;
  logic [15:0] xp_sts = 0;
  logic        e_hpe = 0, e_spe = 0, e_nxm = 0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_host_regs uut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(wr), .host_sel_i(sel), .host_be_i(be), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .host_ack_o(ack), .cmd_load_o(cmd_load), .sub_init_o(sub_init),
    .buf_o(bufv), .ptr_o(ptrv),
    .dma_step_i(step), .dma_down_i(down), .dma_byte_i(bstep),
    .xp_sts_we_i(xp_we), .xp_sts_i(xp_sts),
    .err_hpe_i(e_hpe), .err_spe_i(e_spe), .err_nxm_i(e_nxm)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [15:0] v);
    sel = s;
    #1 v = rdata;
  endtask

  // drive at negedge for one cycle, return at next negedge with inputs idle
  task automatic host_write(input logic s, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    wr = 1; sel = s; be = b; wdata = d;
    @(negedge clk);
    wr = 0; be = 0; sel = 0;
  endtask

  task automatic xp_update(input logic [15:0] v);
    @(negedge clk);
    xp_we = 1; xp_sts = v;
    @(negedge clk);
    xp_we = 0;
  endtask

  task automatic dma(input logic dn, input logic by);
    @(negedge clk);
    step = 1; down = dn; bstep = by;
    @(negedge clk);
    step = 0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(1, v);
    chk("R8 reset status", v & 16'hFCFF, 16'h0400);
    chk("R10 reset ack", ack, 0);
  endtask

  task automatic t_refused_word;
    logic [15:0] v;
    host_write(0, 2'b11, 16'h1237);
    chk("R10 ack on word", ack, 1);
    chk("R6 no strobe when busy", cmd_load, 0);
    chk("R1 word remap", bufv, 18'h31234);
    rd(0, v);
    chk("R2 base read", v, 16'h1234);
    rd(1, v);
    chk("R6 refused status", v, 16'h9700);
    @(negedge clk);
    chk("R10 ack one cycle", ack, 0);
  endtask

  task automatic t_xp_update;
    logic [15:0] v;
    xp_update(16'h048F);
    rd(1, v);
    chk("R9 transport update", v, 16'h178E);
  endtask

  task automatic t_accepted_word;
    logic [15:0] v;
    @(negedge clk); e_nxm = 1;
    @(negedge clk); e_nxm = 0;
    rd(1, v);
    chk("R9 nxm set", v[11], 1);
    host_write(0, 2'b11, 16'hABCD);
    chk("R10 strobe on accepted word", cmd_load, 1);
    chk("R2 pointer load", ptrv, 18'h1ABCC);
    rd(1, v);
    chk("R7 write clears flags", v, 16'h050E);
    @(negedge clk);
    chk("R10 strobe one cycle", cmd_load, 0);
  endtask

  task automatic t_high_byte;
    logic [15:0] v;
    xp_update(16'h0480);
    host_write(0, 2'b10, 16'h5AFF);
    chk("R3 high byte remap", bufv, 18'h25A5A);
    chk("R10 no strobe on byte", cmd_load, 0);
    chk("R10 ack on byte", ack, 1);
    rd(0, v);
    chk("R2 high byte ptr read", v, 16'h5A58);
    rd(1, v);
    chk("R2 status ptr bits", v[9:8], 2'b10);
  endtask

  task automatic t_low_byte;
    host_write(0, 2'b01, 16'h1357);
    chk("R4 low byte remap", bufv, 18'h21357);
    chk("R4 pointer kept", ptrv, 18'h25A58);
  endtask

  task automatic t_dma;
    logic [15:0] v;
    dma(0, 0); chk("R5 word up", ptrv, 18'h25A5A);
    dma(0, 1); chk("R5 byte up", ptrv, 18'h25A5B);
    dma(1, 0); chk("R5 word down", ptrv, 18'h25A59);
    dma(1, 1); chk("R5 byte down", ptrv, 18'h25A58);
    host_write(0, 2'b11, 16'hFFFF);
    chk("R2 top load", ptrv, 18'h3FFFC);
    dma(0, 0); dma(0, 0);
    chk("R5 wrap up", ptrv, 18'h00000);
    rd(1, v);
    chk("R5 wrap status bits", v[9:8], 2'b00);
    dma(1, 1);
    chk("R5 wrap down", ptrv, 18'h3FFFF);
    @(negedge clk);
    wr = 1; sel = 0; be = 2'b11; wdata = 16'h0100; step = 1; down = 0; bstep = 0;
    @(negedge clk);
    wr = 0; be = 0; step = 0;
    chk("R5 load wins over step", ptrv, 18'h00100);
  endtask

  task automatic t_init;
    logic [15:0] v;
    @(negedge clk); e_hpe = 1; e_spe = 1;
    @(negedge clk); e_hpe = 0; e_spe = 0;
    rd(1, v);
    chk("R9 parity flags set", v[14:13], 2'b11);
    host_write(1, 2'b11, 16'hFFFF);
    chk("R8 init strobe", sub_init, 1);
    chk("R10 ack on init", ack, 1);
    rd(1, v);
    chk("R8 init status", v, 16'h0400);
    chk("R8 buffer kept", bufv, 18'h00100);
    rd(0, v);
    chk("R8 pointer kept", v, 16'h0100);
    @(negedge clk);
    chk("R8 init strobe one cycle", sub_init, 0);
  endtask

  task automatic t_ignored;
    host_write(0, 2'b00, 16'hDEAD);
    chk("R10 no ack on empty enables", ack, 0);
    chk("R10 buffer unchanged", bufv, 18'h00100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_refused_word();
    t_xp_update();
    t_accepted_word();
    t_high_byte();
    t_low_byte();
    t_dma();
    t_init();
    t_ignored();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule